// File: doc/BRIEF.md
# Network Controller Command/Status Register Pair

This block is the register pair through which a host steers a network controller. A 16-bit status word collects interrupt causes and reports the current state of the command unit and the receive unit. A 16-bit command word takes a command for each unit, an interrupt-disable bit and a software-interrupt trigger. The block drives a single interrupt line to the host.

Each unit command waits in the command word until that unit takes it. A command waiting for a unit is offered as a valid/code pair. The unit answers with a one-cycle accept strobe, and the field then drops back to zero. The host polls the command word until both fields read zero before it writes again. The units report events on a cause-event vector. The host clears causes by writing ones to them in the status word.

Top module: `scb_regs`

## Requirements
- R1: After reset the cause bits (status 15:8) are 0, the command word reads 0x0000, both valid outputs are low and `irq` is low.
- R2: A 1 on `cause_evt[k]` sets status bit 8+k on the next clock. The settable bits are 15 (command done), 14 (frame received), 13 (command unit left active), 12 (receiver left ready), 11 (management cycle done) and 8 (pause). `cause_evt[1]` and `cause_evt[2]` have no effect.
- R3: A write to the status word (`wr_sel`=0) clears every cause bit written as 1 within mask 0xFD00. Bits written as 0 are left unchanged.
- R4: When a cause event and a clear of the same bit fall in the same cycle, the bit stays set.
- R5: A nonzero value written to command bits 7:4 while the command-unit field is zero is stored there. It reads back, and it is driven on `cu_cmd_code` with `cu_cmd_valid` high. The cycle after `cu_cmd_accept` is seen with valid high, the field reads 0.
- R6: The same applies to command bits 2:0 for the receive unit, with `ru_cmd_valid`, `ru_cmd_code` and `ru_cmd_accept`.
- R7: A command written while its field is nonzero is ignored, and the pending code is kept.
- R8: Command bit 8 is stored and reads back. `irq` is high exactly when some cause bit is set and bit 8 is 0.
- R9: Writing 1 to command bit 9 sets status bit 10 (software interrupt). Command bit 9 always reads 0.
- R10: Status bits 7:6 show `cu_state` and bits 5:2 show `ru_state`. Status bits 9, 1 and 0 and command bits 15:10 and 3 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 1 | 0 selects the status word, 1 selects the command word |
| wr_data | input | 16 | Host write data |
| rd_status | output | 16 | Status word |
| rd_command | output | 16 | Command word |
| cause_evt | input | 8 | Cause events; bit k sets status bit 8+k |
| cu_state | input | 2 | Command-unit state |
| ru_state | input | 4 | Receive-unit state |
| cu_cmd_valid | output | 1 | Command-unit command pending |
| cu_cmd_code | output | 4 | Pending command-unit code |
| cu_cmd_accept | input | 1 | Command unit takes the pending code |
| ru_cmd_valid | output | 1 | Receive-unit command pending |
| ru_cmd_code | output | 3 | Pending receive-unit code |
| ru_cmd_accept | input | 1 | Receive unit takes the pending code |
| irq | output | 1 | Interrupt to host |

## Verification
The assertions assume that each unit raises its accept strobe only while its valid output is high, and for one cycle at a time. The bench follows this: it pulses an accept only after a command has been placed, and it releases the strobe at the next sample point. Cause events and the state inputs are taken as synchronous one-cycle pulses and levels. The bench changes them only on the falling edge.

// File: rtl/scb_pkg.sv
package scb_pkg;
  localparam int WORD_W   = 16;
  localparam int CAUSE_W  = 8;   // status bits 15:8
  localparam logic [CAUSE_W-1:0] ACK_MASK = 8'hFD;  // clearable causes
  localparam logic [CAUSE_W-1:0] EVT_MASK = 8'hF9;  // causes a unit may raise
  localparam int SWI_IDX  = 2;   // status bit 10

  // Next cause vector: clear written ones first, new events win.
  function automatic logic [CAUSE_W-1:0] cause_next(
      input logic [CAUSE_W-1:0] cur,
      input logic [CAUSE_W-1:0] clr,
      input logic [CAUSE_W-1:0] set);
    return (cur & ~(clr & ACK_MASK)) | set;
  endfunction

  // Next pending code of a command field.
  function automatic logic [3:0] slot_next(
      input logic [3:0] cur,
      input logic       wr,
      input logic [3:0] code,
      input logic       take);
    logic [3:0] n;
    n = cur;
    if (cur != '0 && take) n = '0;
    else if (cur == '0 && wr) n = code;
    return n;
  endfunction
endpackage

// File: rtl/scb_cause_reg.sv
module scb_cause_reg
  import scb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CAUSE_W-1:0] clr_bits,
  input  logic [CAUSE_W-1:0] set_bits,
  output logic [CAUSE_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= cause_next(q, clr_bits, set_bits);
  end
endmodule

// File: rtl/scb_cmd_slot.sv
module scb_cmd_slot #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wr_code,
  input  logic         take,
  output logic [W-1:0] code,
  output logic         valid
);
  localparam int PAD = 4 - W;
  logic [3:0] nxt;
  logic [3:0] cur4;
  logic [3:0] code4;

  generate
    if (PAD > 0) begin : g_pad
      assign cur4  = {{PAD{1'b0}}, code};
      assign code4 = {{PAD{1'b0}}, wr_code};
    end else begin : g_nopad
      assign cur4  = code;
      assign code4 = wr_code;
    end
  endgenerate

  assign nxt = scb_pkg::slot_next(cur4, wr, code4, take);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code <= '0;
    else        code <= nxt[W-1:0];
  end

  assign valid = (code != '0);

  logic unused_hi;
  assign unused_hi = ^nxt;
endmodule

// File: rtl/scb_regs.sv
module scb_regs
  import scb_pkg::*;
#(
  parameter int CU_W  = 4,
  parameter int RU_W  = 3,
  parameter int CUS_W = 2,
  parameter int RUS_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [15:0]       wr_data,
  output logic [15:0]       rd_status,
  output logic [15:0]       rd_command,
  input  logic [7:0]        cause_evt,
  input  logic [CUS_W-1:0]  cu_state,
  input  logic [RUS_W-1:0]  ru_state,
  output logic              cu_cmd_valid,
  output logic [CU_W-1:0]   cu_cmd_code,
  input  logic              cu_cmd_accept,
  output logic              ru_cmd_valid,
  output logic [RU_W-1:0]   ru_cmd_code,
  input  logic              ru_cmd_accept,
  output logic              irq
);
  localparam int CU_LSB = 4;
  localparam int MASK_B = 8;
  localparam int SWI_B  = 9;

  // Named internal events, visible to the checker.
  logic               wr_stat, wr_cmd;
  logic [CAUSE_W-1:0] clr_vec, set_vec, cause_q;
  logic               mask_q;

  assign wr_stat = wr_en && !wr_sel;
  assign wr_cmd  = wr_en &&  wr_sel;
  assign clr_vec = wr_stat ? wr_data[15:8] : '0;
  assign set_vec = (cause_evt & EVT_MASK) |
                   ((wr_cmd && wr_data[SWI_B]) ? CAUSE_W'(1 << SWI_IDX) : '0);

  scb_cause_reg u_cause (
    .clk(clk), .rst_n(rst_n),
    .clr_bits(clr_vec), .set_bits(set_vec), .q(cause_q));

  scb_cmd_slot #(.W(CU_W)) u_cu (
    .clk(clk), .rst_n(rst_n),
    .wr(wr_cmd), .wr_code(wr_data[CU_LSB +: CU_W]), .take(cu_cmd_accept),
    .code(cu_cmd_code), .valid(cu_cmd_valid));

  scb_cmd_slot #(.W(RU_W)) u_ru (
    .clk(clk), .rst_n(rst_n),
    .wr(wr_cmd), .wr_code(wr_data[RU_W-1:0]), .take(ru_cmd_accept),
    .code(ru_cmd_code), .valid(ru_cmd_valid));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mask_q <= 1'b0;
    else if (wr_cmd) mask_q <= wr_data[MASK_B];
  end

  assign rd_status  = {cause_q, cu_state, ru_state, 2'b00};
  assign rd_command = {6'b0, 1'b0, mask_q, cu_cmd_code, 1'b0, ru_cmd_code};
  assign irq        = (|cause_q) && !mask_q;

  logic unused_wr;
  assign unused_wr = ^{wr_data[15:10], wr_data[3], wr_data[7:0]};
endmodule

// File: rtl/scb_regs_chk.sv
module scb_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] rd_status,
  input logic [15:0] rd_command,
  input logic [7:0]  set_vec,
  input logic        cu_cmd_valid,
  input logic [3:0]  cu_cmd_code,
  input logic        cu_cmd_accept,
  input logic        ru_cmd_valid,
  input logic [2:0]  ru_cmd_code,
  input logic        ru_cmd_accept,
  input logic        irq
);
  AST_CU_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    cu_cmd_valid && cu_cmd_accept |=> !cu_cmd_valid);  // R5
  AST_RU_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    ru_cmd_valid && ru_cmd_accept |=> !ru_cmd_valid);  // R6
  AST_CU_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    cu_cmd_valid && !cu_cmd_accept |=> cu_cmd_valid && $stable(cu_cmd_code));  // R7
  AST_RU_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ru_cmd_valid && !ru_cmd_accept |=> ru_cmd_valid && $stable(ru_cmd_code));  // R7
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((rd_status[15:8] & $past(set_vec)) == $past(set_vec)));  // R4
  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    rd_command[8] |-> !irq);  // R8
endmodule

bind scb_regs scb_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_status(rd_status), .rd_command(rd_command),
  .set_vec(set_vec), .cu_cmd_valid(cu_cmd_valid), .cu_cmd_code(cu_cmd_code),
  .cu_cmd_accept(cu_cmd_accept), .ru_cmd_valid(ru_cmd_valid),
  .ru_cmd_code(ru_cmd_code), .ru_cmd_accept(ru_cmd_accept), .irq(irq));

// File: tb/sim_scb_regs.sv
module sim_scb_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_sel = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_status, rd_command;
  logic [7:0]  cause_evt = '0;
  logic [1:0]  cu_state = 2'b10;
  logic [3:0]  ru_state = 4'b0100;
  logic        cu_cmd_valid, ru_cmd_valid, irq;
  logic [3:0]  cu_cmd_code;
  logic [2:0]  ru_cmd_code;
  logic        cu_cmd_accept = 1'b0, ru_cmd_accept = 1'b0;

  int total = 0, bad = 0, cycles = 0;

  always #2 clk = ~clk;

  scb_regs u0 (.*);

  // op: 0 idle, 1 write status, 2 write command, 3 accept cu, 4 accept ru
  // row = {op, data, evt, exp_status, exp_command, exp_irq}; state bits give 0x0090
  localparam int N = 16;
  localparam logic [59:0] ROWS [N] = '{
    {3'd0, 16'h0000, 8'h01, 16'h0190, 16'h0000, 1'b1},  // R2 pause
    {3'd0, 16'h0000, 8'h80, 16'h8190, 16'h0000, 1'b1},  // R2 command done
    {3'd1, 16'h0100, 8'h00, 16'h8090, 16'h0000, 1'b1},  // R3 clear one
    {3'd1, 16'h8000, 8'h80, 16'h8090, 16'h0000, 1'b1},  // R4 event wins
    {3'd1, 16'h8000, 8'h00, 16'h0090, 16'h0000, 1'b0},  // R3 clear last
    {3'd0, 16'h0000, 8'h06, 16'h0090, 16'h0000, 1'b0},  // R2 ignored bits
    {3'd2, 16'h0100, 8'h00, 16'h0090, 16'h0100, 1'b0},  // R8 mask set
    {3'd0, 16'h0000, 8'h40, 16'h4090, 16'h0100, 1'b0},  // R8 masked
    {3'd2, 16'h0000, 8'h00, 16'h4090, 16'h0000, 1'b1},  // R8 unmasked
    {3'd2, 16'h0010, 8'h00, 16'h4090, 16'h0010, 1'b1},  // R5 cu start
    {3'd2, 16'h0061, 8'h00, 16'h4090, 16'h0011, 1'b1},  // R7 cu kept, R6 ru start
    {3'd3, 16'h0000, 8'h00, 16'h4090, 16'h0001, 1'b1},  // R5 cu taken
    {3'd2, 16'h0004, 8'h00, 16'h4090, 16'h0001, 1'b1},  // R7 ru kept
    {3'd4, 16'h0000, 8'h00, 16'h4090, 16'h0000, 1'b1},  // R6 ru taken
    {3'd2, 16'h0200, 8'h00, 16'h4490, 16'h0000, 1'b1},  // R9 software int
    {3'd1, 16'hFFFF, 8'h00, 16'h0090, 16'h0000, 1'b0}   // R3 clear all
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] op, input logic [15:0] d, input logic [7:0] ev);
    @(negedge clk);
    wr_en = (op == 3'd1 || op == 3'd2);
    wr_sel = (op == 3'd2);
    wr_data = d;
    cause_evt = ev;
    cu_cmd_accept = (op == 3'd3);
    ru_cmd_accept = (op == 3'd4);
    @(negedge clk);
    wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0; cause_evt = '0;
    cu_cmd_accept = 1'b0; ru_cmd_accept = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected<5000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1 status", rd_status, 16'h0090);
    chk("R1 command", rd_command, 16'h0000);
    chk("R1 valid/irq", {13'b0, cu_cmd_valid, ru_cmd_valid, irq}, 16'h0000);
    rst_n = 1'b1;

    for (int i = 0; i < N; i++) begin
      step(ROWS[i][59:57], ROWS[i][56:41], ROWS[i][40:33]);
      chk($sformatf("row%0d status", i), rd_status, ROWS[i][32:17]);
      chk($sformatf("row%0d command", i), rd_command, ROWS[i][16:1]);
      chk($sformatf("row%0d irq", i), {15'b0, irq}, {15'b0, ROWS[i][0]});
    end

    // R5 handshake outputs while pending
    step(3'd2, 16'h0070, 8'h00);
    chk("R5 cu code/valid", {11'b0, cu_cmd_valid, cu_cmd_code}, {11'b0, 1'b1, 4'h7});
    // R6 ru handshake outputs
    step(3'd2, 16'h0007, 8'h00);
    chk("R6 ru code/valid", {12'b0, ru_cmd_valid, ru_cmd_code}, {12'b0, 1'b1, 3'h7});
    step(3'd3, 16'h0000, 8'h00);
    step(3'd4, 16'h0000, 8'h00);
    chk("R5 R6 both taken", {14'b0, cu_cmd_valid, ru_cmd_valid}, 16'h0000);
    // R7 accept with nothing pending keeps fields zero; new write then lands
    step(3'd3, 16'h0000, 8'h00);
    step(3'd2, 16'h0022, 8'h00);
    chk("R7 fresh write after idle accept", rd_command, 16'h0022);
    step(3'd3, 16'h0000, 8'h00);
    step(3'd4, 16'h0000, 8'h00);
    // R10 state mapping and reserved bits
    @(negedge clk);
    cu_state = 2'b01; ru_state = 4'b1010;
    step(3'd2, 16'hFC08, 8'h00);
    chk("R10 status", rd_status, 16'h0068);
    chk("R10 command reserved", rd_command, 16'h0000);
    // R9 software interrupt with mask held
    step(3'd2, 16'h0300, 8'h00);
    chk("R9 swi masked status", rd_status, 16'h0468);
    chk("R9 bit9 reads 0", rd_command, 16'h0100);
    chk("R8 irq masked", {15'b0, irq}, 16'h0000);
    // R1 reset again clears everything
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset status", rd_status, 16'h0068);
    chk("R1 reset command", rd_command, 16'h0000);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule